// File: doc/BRIEF.md
# Page Pattern Verify Counter

This block sits behind a NAND read path during wear testing and checks each page of data as it streams back. The controller first pulses a start strobe together with the check settings. Data bytes then arrive with a valid qualifier, and the final byte of the page carries a last marker. Every accepted byte is compared with an expected byte. In the erase check the expected byte is all ones. In the program check the expected byte is either a fixed byte or the output of a seeded pseudo-random generator. The generator is rebuilt on the fly in the same way as the data was produced when the page was programmed, so the pattern never has to be stored.

For each page the block counts the differing bits and the differing bytes. One cycle after the last byte it raises a done pulse. It then holds the two counts and a pass flag, which is set when no bit differed, until the next start.

Top module: `page_verify_counter`

## Requirements
- R1: After reset, done_o and pass_o are 0 and both error counts are 0.
- R2: A start_i pulse clears both counts, pass_o and done_o in the next cycle. The same pulse captures chk_mode_i, pat_rand_i, fixed_byte_i and seed_i for the whole page, so later changes on those inputs have no effect until the next start.
- R3: With chk_mode_i = 0 (erase check), every accepted byte is compared against 8'hFF.
- R4: With chk_mode_i = 1 and pat_rand_i = 0, every accepted byte is compared against the captured fixed_byte_i.
- R5: With chk_mode_i = 1 and pat_rand_i = 1, the expected byte is the low 8 bits of a 32-bit generator state. The state is loaded with seed_i at start. After each accepted byte it advances by 8 single steps. A single step shifts the state right by one and, when the bit shifted out was 1, XORs the state with 32'h80200003.
- R6: For each accepted byte, the bit count grows by the number of ones in data XOR expected, and the byte count grows by one when that XOR is nonzero.
- R7: In the cycle after the byte accepted with last_i, done_o is 1 for exactly one cycle and pass_o is 1 exactly when the bit count is 0. The counts stay unchanged until the next start.
- R8: A byte is accepted only when valid_i is 1. A cycle with valid_i low changes neither the counts nor the generator state.
- R9: Bytes are accepted only after a start and up to and including the byte marked last. A byte presented in the same cycle as start_i is dropped.
- R10: The counts saturate at their maximum values (32767 bits, 4095 bytes with default parameters) and never wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a page: clear counts, capture settings |
| chk_mode_i | input | 1 | 0 erase check, 1 program check |
| pat_rand_i | input | 1 | Program check source: 0 fixed byte, 1 pseudo-random |
| fixed_byte_i | input | 8 | Fixed expected byte |
| seed_i | input | 32 | Generator seed |
| data_i | input | 8 | Read-back data byte |
| valid_i | input | 1 | data_i carries a byte this cycle |
| last_i | input | 1 | This byte ends the page |
| done_o | output | 1 | One-cycle pulse after the last byte |
| pass_o | output | 1 | Page had no bit errors |
| bit_err_o | output | 15 | Mismatching bit count |
| byte_err_o | output | 12 | Mismatching byte count |

## Verification
The bench inserts idle cycles that carry garbage data between bytes. A design that counted those bytes, or that stepped the generator on them, would report errors on pages that are clean. It changes the settings inputs right after start, which catches a design that reads them live instead of capturing them. It sends bytes before any start, after the last byte, and in the same cycle as start. A design that accepted any of these would change the held counts or raise a stray done. It also streams a full 2112-byte page and an over-long page of 4100 all-wrong bytes. A counter that is too narrow or that wraps would give a small or wrong total instead of the saturated maximum.

// File: rtl/pvc_pkg.sv
package pvc_pkg;
  typedef enum logic {CHK_ERASE = 1'b0, CHK_PROGRAM = 1'b1} chk_mode_e;

  parameter int LFSR_W = 32;
  parameter logic [LFSR_W-1:0] LFSR_POLY = 32'h80200003;

  // Advance the right-shifting Galois generator by a number of single steps.
  function automatic logic [LFSR_W-1:0] lfsr_advance(input logic [LFSR_W-1:0] s,
                                                     input int steps);
    logic [LFSR_W-1:0] r;
    r = s;
    for (int k = 0; k < steps; k++) begin
      r = (r >> 1) ^ (r[0] ? LFSR_POLY : '0);
    end
    return r;
  endfunction
endpackage

// File: rtl/pvc_pattern_gen.sv
module pvc_pattern_gen #(
  parameter int DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load_i,
  input  logic                      adv_i,
  input  logic                      mode_i,
  input  logic                      rand_i,
  input  logic [DATA_W-1:0]         fixed_i,
  input  logic [pvc_pkg::LFSR_W-1:0] seed_i,
  output logic [DATA_W-1:0]         exp_o
);
  import pvc_pkg::*;

  logic [LFSR_W-1:0] state_q;
  chk_mode_e         mode_q;
  logic              rand_q;
  logic [DATA_W-1:0] fixed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      mode_q  <= CHK_ERASE;
      rand_q  <= 1'b0;
      fixed_q <= '0;
    end else if (load_i) begin
      state_q <= seed_i;
      mode_q  <= chk_mode_e'(mode_i);
      rand_q  <= rand_i;
      fixed_q <= fixed_i;
    end else if (adv_i) begin
      state_q <= lfsr_advance(state_q, DATA_W);
    end
  end

  always_comb begin
    if (mode_q == CHK_ERASE)  exp_o = '1;
    else if (rand_q)          exp_o = state_q[DATA_W-1:0];
    else                      exp_o = fixed_q;
  end

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != '0 && !load_i) |=> (state_q != '0)); // R5
  AST_LFSR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_i && !load_i) |=> $stable(state_q)); // R8
endmodule

// File: rtl/pvc_mismatch.sv
module pvc_mismatch #(
  parameter int DATA_W = 8,
  localparam int NB_W = $clog2(DATA_W + 1)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] exp_i,
  output logic [NB_W-1:0]   nbits_o,
  output logic              any_o
);
  function automatic logic [NB_W-1:0] ones_of(input logic [DATA_W-1:0] v);
    logic [NB_W-1:0] n;
    n = '0;
    for (int k = 0; k < DATA_W; k++) n = n + NB_W'(v[k]);
    return n;
  endfunction

  logic [DATA_W-1:0] diff;
  assign diff    = data_i ^ exp_i;
  assign nbits_o = ones_of(diff);
  assign any_o   = |diff;
endmodule

// File: rtl/pvc_accum.sv
module pvc_accum #(
  parameter int BIT_W  = 15,
  parameter int BYTE_W = 12,
  parameter int NB_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              take_i,
  input  logic              last_i,
  input  logic [NB_W-1:0]   nbits_i,
  input  logic              any_i,
  output logic              armed_o,
  output logic              done_o,
  output logic              pass_o,
  output logic [BIT_W-1:0]  bit_o,
  output logic [BYTE_W-1:0] byte_o
);
  logic [BIT_W-1:0]  bit_q, bit_next;
  logic [BYTE_W-1:0] byte_q, byte_next;
  logic [BIT_W:0]    bit_sum;
  logic              armed_q, done_q, pass_q;

  always_comb begin
    bit_sum   = {1'b0, bit_q} + (BIT_W+1)'(nbits_i);
    bit_next  = bit_sum[BIT_W] ? '1 : bit_sum[BIT_W-1:0];
    byte_next = (any_i && byte_q != '1) ? byte_q + 1'b1 : byte_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q   <= '0;
      byte_q  <= '0;
      armed_q <= 1'b0;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
    end else if (start_i) begin
      bit_q   <= '0;
      byte_q  <= '0;
      armed_q <= 1'b1;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (take_i) begin
        bit_q  <= bit_next;
        byte_q <= byte_next;
        if (last_i) begin
          armed_q <= 1'b0;
          done_q  <= 1'b1;
          pass_q  <= (bit_next == '0);
        end
      end
    end
  end

  assign armed_o = armed_q;
  assign done_o  = done_q;
  assign pass_o  = pass_q;
  assign bit_o   = bit_q;
  assign byte_o  = byte_q;

  AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (bit_q == '0 && byte_q == '0 && !done_q && !pass_q)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R7
  AST_PASS_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (pass_q == (bit_q == '0))); // R7
  AST_BYTE_NOT_ABOVE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (BIT_W'(byte_q) <= bit_q)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_i && !start_i) |=> ($stable(bit_q) && $stable(byte_q))); // R9
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !start_i) |=> (bit_q >= $past(bit_q) && byte_q >= $past(byte_q))); // R10
endmodule

// File: rtl/page_verify_counter.sv
module page_verify_counter #(
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 2112,
  localparam int BIT_W  = $clog2(PAGE_BYTES * DATA_W + 1),
  localparam int BYTE_W = $clog2(PAGE_BYTES + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic                       chk_mode_i,
  input  logic                       pat_rand_i,
  input  logic [DATA_W-1:0]          fixed_byte_i,
  input  logic [pvc_pkg::LFSR_W-1:0] seed_i,
  input  logic [DATA_W-1:0]          data_i,
  input  logic                       valid_i,
  input  logic                       last_i,
  output logic                       done_o,
  output logic                       pass_o,
  output logic [BIT_W-1:0]           bit_err_o,
  output logic [BYTE_W-1:0]          byte_err_o
);
  localparam int NB_W = $clog2(DATA_W + 1);

  logic              armed;
  logic              take;
  logic [DATA_W-1:0] exp_byte;
  logic [NB_W-1:0]   nbits;
  logic              any_diff;

  assign take = valid_i && armed && !start_i;

  pvc_pattern_gen #(.DATA_W(DATA_W)) u_pat (
    .clk(clk), .rst_n(rst_n), .load_i(start_i), .adv_i(take),
    .mode_i(chk_mode_i), .rand_i(pat_rand_i), .fixed_i(fixed_byte_i),
    .seed_i(seed_i), .exp_o(exp_byte)
  );

  pvc_mismatch #(.DATA_W(DATA_W)) u_cmp (
    .data_i(data_i), .exp_i(exp_byte), .nbits_o(nbits), .any_o(any_diff)
  );

  pvc_accum #(.BIT_W(BIT_W), .BYTE_W(BYTE_W), .NB_W(NB_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .take_i(take),
    .last_i(last_i), .nbits_i(nbits), .any_i(any_diff), .armed_o(armed),
    .done_o(done_o), .pass_o(pass_o), .bit_o(bit_err_o), .byte_o(byte_err_o)
  );

  AST_UNARMED_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !start_i) |=> !done_o); // R9
endmodule

// File: tb/test_page_verify_counter.sv
`timescale 1ns/1ps
module test_page_verify_counter;
  localparam int BIT_MAX  = 32767;
  localparam int BYTE_MAX = 4095;
  localparam int NV = 8;
  // {mode, rand, fixed[7:0], seed[31:0], len[12:0], mask[7:0], period[7:0]}
  localparam logic [70:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'h00, 32'h00000000, 13'd32,   8'h00, 8'd1},
    {1'b0, 1'b0, 8'h00, 32'h00000000, 13'd40,   8'h81, 8'd5},
    {1'b1, 1'b0, 8'hA5, 32'h00000000, 13'd24,   8'h00, 8'd1},
    {1'b1, 1'b0, 8'h3C, 32'h00000000, 13'd50,   8'hFF, 8'd7},
    {1'b1, 1'b1, 8'h00, 32'hACE12345, 13'd64,   8'h00, 8'd1},
    {1'b1, 1'b1, 8'h00, 32'h00000001, 13'd30,   8'h10, 8'd3},
    {1'b0, 1'b0, 8'h00, 32'h00000000, 13'd2112, 8'h01, 8'd1},
    {1'b0, 1'b0, 8'h00, 32'h00000000, 13'd4100, 8'hFF, 8'd1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, chk_mode_i = 1'b0, pat_rand_i = 1'b0;
  logic [7:0]  fixed_byte_i = '0, data_i = '0;
  logic [31:0] seed_i = '0;
  logic        valid_i = 1'b0, last_i = 1'b0;
  logic        done_o, pass_o;
  logic [14:0] bit_err_o;
  logic [11:0] byte_err_o;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  page_verify_counter i_page_verify_counter (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .chk_mode_i(chk_mode_i),
    .pat_rand_i(pat_rand_i), .fixed_byte_i(fixed_byte_i), .seed_i(seed_i),
    .data_i(data_i), .valid_i(valid_i), .last_i(last_i), .done_o(done_o),
    .pass_o(pass_o), .bit_err_o(bit_err_o), .byte_err_o(byte_err_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Bench model of the generator, one bit at a time.
  function automatic logic [31:0] gen_byte_step(input logic [31:0] s);
    logic [31:0] r;
    r = s;
    for (int b = 0; b < 8; b++) begin
      if (r[0]) r = {1'b0, r[31:1]} ^ 32'h80200003;
      else      r = {1'b0, r[31:1]};
    end
    return r;
  endfunction

  function automatic int ones8(input logic [7:0] v);
    int n = 0;
    for (int b = 0; b < 8; b++) if (v[b]) n++;
    return n;
  endfunction

  task automatic run_page(input logic [70:0] v, input string req);
    logic        m  = v[70];
    logic        rn = v[69];
    logic [7:0]  fx = v[68:61];
    logic [31:0] sd = v[60:29];
    int          len = int'(v[28:16]);
    logic [7:0]  mk = v[15:8];
    int          per = int'(v[7:0]);
    logic [31:0] st = sd;
    logic [7:0]  ex;
    int eb = 0, ey = 0;
    @(negedge clk);
    start_i = 1'b1; chk_mode_i = m; pat_rand_i = rn; fixed_byte_i = fx; seed_i = sd;
    @(negedge clk);
    start_i = 1'b0; chk_mode_i = ~m; pat_rand_i = ~rn; fixed_byte_i = ~fx; seed_i = ~sd;
    for (int i = 0; i < len; i++) begin
      if (i % 4 == 3) begin
        valid_i = 1'b0; last_i = 1'b1; data_i = 8'h5A ^ 8'(i);
        @(negedge clk);
      end
      ex = !m ? 8'hFF : (rn ? st[7:0] : fx);
      data_i = ((i % per) == 0) ? (ex ^ mk) : ex;
      if ((i % per) == 0 && mk != 8'h00) begin eb += ones8(mk); ey++; end
      valid_i = 1'b1; last_i = (i == len - 1);
      st = gen_byte_step(st);
      @(negedge clk);
    end
    valid_i = 1'b0; last_i = 1'b0;
    if (eb > BIT_MAX) eb = BIT_MAX;
    if (ey > BYTE_MAX) ey = BYTE_MAX;
    #1;
    check({req, " R7 done"}, int'(done_o), 1);
    check({req, " R6 bits"}, int'(bit_err_o), eb);
    check({req, " R6 bytes"}, int'(byte_err_o), ey);
    check({req, " R7 pass"}, int'(pass_o), int'(eb == 0));
    @(negedge clk); #1;
    check({req, " R7 done pulse"}, int'(done_o), 0);
    check({req, " R7 counts held"}, int'(bit_err_o), eb);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 done", int'(done_o), 0);
    check("R1 pass", int'(pass_o), 0);
    check("R1 bits", int'(bit_err_o), 0);
    check("R1 bytes", int'(byte_err_o), 0);
    rst_n = 1'b1;

    // R9: bytes before any start are ignored
    @(negedge clk);
    data_i = 8'h00; valid_i = 1'b1; last_i = 1'b0;
    repeat (3) @(negedge clk);
    last_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0; last_i = 1'b0;
    @(negedge clk); #1;
    check("R9 no done before start", int'(done_o), 0);
    check("R9 no count before start", int'(bit_err_o), 0);

    begin : walk
      string tags [NV] = '{"R3", "R3", "R4", "R4", "R5", "R5", "R3 full page", "R10"};
      for (int t = 0; t < NV; t++) run_page(VEC[t], tags[t]);
    end

    // R9: bytes after last are ignored; counts stay saturated
    @(negedge clk);
    data_i = 8'h00; valid_i = 1'b1; last_i = 1'b0;
    repeat (4) @(negedge clk);
    last_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0; last_i = 1'b0;
    @(negedge clk); #1;
    check("R9 no done after last", int'(done_o), 0);
    check("R9 bits held after last", int'(bit_err_o), BIT_MAX);
    check("R10 bytes held saturated", int'(byte_err_o), BYTE_MAX);

    // R2 + R9: start clears; byte with start is dropped
    @(negedge clk);
    start_i = 1'b1; chk_mode_i = 1'b0; pat_rand_i = 1'b0;
    data_i = 8'h00; valid_i = 1'b1; last_i = 1'b0;
    @(negedge clk); #1;
    check("R2 bits cleared", int'(bit_err_o), 0);
    check("R2 bytes cleared", int'(byte_err_o), 0);
    check("R2 pass cleared", int'(pass_o), 0);
    start_i = 1'b0; data_i = 8'hFF; valid_i = 1'b1;
    @(negedge clk);
    last_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0; last_i = 1'b0; #1;
    check("R9 start byte dropped done", int'(done_o), 1);
    check("R9 start byte dropped bits", int'(bit_err_o), 0);
    check("R9 start byte dropped pass", int'(pass_o), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule